// File: doc/BRIEF.md
# V5 Signal Label Monitor

This block watches the 3-bit signal label that a virtual-tributary path carries once per superframe in its V5 overhead byte. A persistence filter guards the label. It accepts a new value only after that value has arrived in a programmable number of consecutive superframes. Any different value in between restarts the run.

Two path defects come from the accepted label:
- **Unequipped (UNEQ)** is raised when the accepted label is all zeros.
- **Payload label mismatch (PLM)** is raised when the accepted label differs from a programmed expected label. The PLM check is suppressed while UNEQ is active and whenever the expected label is 001.

Each defect has a sticky change-of-state flag and a mask bit. The unmasked flags are combined into one interrupt. UNEQ also leaves the block as a contributor to the automatic AIS request. The AIS insertion logic and the processor bus sit elsewhere: they pulse the clear inputs and read the outputs.

Top module: `vt_label_mon`

## Requirements
- R1: The received label is V5 bits 5 to 7, which is `v5_byte[3:1]`. `v5_byte[3]` is the label MSB. The other V5 bits, and `v5_byte` in any cycle where `sf_valid` is low, have no effect on any output.
- R2: The persistence filter works as follows.
  - A run counter counts consecutive identical labels.
  - A label different from the previous one restarts the run at 1.
  - When the run reaches the threshold, that label becomes the accepted label. The threshold is `persist_n`, and a value of 0 is treated as 1.
  - The counter saturates at 15.
- R3: `acc_label` takes its new value at the clock edge that samples the superframe completing the run. `uneq` and `plm` are re-evaluated on the edge that follows every superframe.
- R4: `uneq` is 1 exactly when the accepted label is 000 at evaluation. `ais_uneq` always equals `uneq`.
- R5: `plm` is 1 when the accepted label differs from `exp_label`, except that `plm` is held at 0 while the accepted label is 000 or `exp_label` is 001.
- R6: `uneq_delta` and `plm_delta` set on any change of their defect and hold until a `uneq_clr` or `plm_clr` pulse. A set in the same cycle as a clear wins.
- R7: `irq` is high when `uneq_delta` is set with `uneq_mask` low, or when `plm_delta` is set with `plm_mask` low.
- R8: After reset, `acc_label` is 000, `uneq`, `plm`, both delta flags and `irq` are 0, and the run counter is empty.
- R9: A new `exp_label` takes effect at the next superframe's evaluation. It does not restart the persistence filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | One-cycle strobe: `v5_byte` holds this superframe's V5 |
| v5_byte | input | 8 | Received V5 byte |
| persist_n | input | 4 | Consecutive receptions needed to accept a label |
| exp_label | input | 3 | Expected signal label |
| uneq_mask | input | 1 | Masks UNEQ change from `irq` |
| plm_mask | input | 1 | Masks PLM change from `irq` |
| uneq_clr | input | 1 | Clears `uneq_delta` |
| plm_clr | input | 1 | Clears `plm_delta` |
| acc_label | output | 3 | Accepted (filtered) label |
| uneq | output | 1 | Unequipped defect |
| plm | output | 1 | Payload label mismatch defect |
| uneq_delta | output | 1 | UNEQ change-of-state flag |
| plm_delta | output | 1 | PLM change-of-state flag |
| irq | output | 1 | Interrupt |
| ais_uneq | output | 1 | UNEQ contribution to AIS request |

## Verification
The outputs are due at different times after a superframe strobe:
- `acc_label` is due one edge after the strobe.
- The defects and their delta flags are due one edge later.
- `irq` follows the flags without delay.

The bench drives each superframe on a falling edge. It compares `acc_label` just after the sampling edge, then compares the defects, flags and interrupt after the next edge. Superframes are always spaced by idle cycles so that the two windows never overlap. Clears and changes to the expected label are applied only in idle gaps, so the bench model knows which values the evaluation sees.

// File: rtl/vt_label_mon.sv
module vt_label_mon #(
  parameter int LBL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_valid,
  input  logic [7:0]       v5_byte,
  input  logic [CNT_W-1:0] persist_n,
  input  logic [LBL_W-1:0] exp_label,
  input  logic             uneq_mask,
  input  logic             plm_mask,
  input  logic             uneq_clr,
  input  logic             plm_clr,
  output logic [LBL_W-1:0] acc_label,
  output logic             uneq,
  output logic             plm,
  output logic             uneq_delta,
  output logic             plm_delta,
  output logic             irq,
  output logic             ais_uneq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [LBL_W-1:0] LBL_NOCHK = LBL_W'(1);

  logic [LBL_W-1:0] rx_lbl, cand_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx, thr;
  logic             eval_q, uneq_nx, plm_nx;

  assign rx_lbl = v5_byte[3:1];
  assign thr    = (persist_n == '0) ? CNT_W'(1) : persist_n;
  assign cnt_nx = (rx_lbl != cand_q) ? CNT_W'(1) :
                  (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q    <= '0;
      cnt_q     <= '0;
      acc_label <= '0;
      eval_q    <= 1'b0;
    end else begin
      eval_q <= sf_valid;
      if (sf_valid) begin
        cand_q <= rx_lbl;
        cnt_q  <= cnt_nx;
        if (cnt_nx >= thr) acc_label <= rx_lbl;
      end
    end
  end

  assign uneq_nx = (acc_label == '0);
  assign plm_nx  = !uneq_nx && (exp_label != LBL_NOCHK) && (acc_label != exp_label);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uneq       <= 1'b0;
      plm        <= 1'b0;
      uneq_delta <= 1'b0;
      plm_delta  <= 1'b0;
    end else begin
      if (eval_q) begin
        uneq <= uneq_nx;
        plm  <= plm_nx;
      end
      if (eval_q && (uneq_nx != uneq)) uneq_delta <= 1'b1;
      else if (uneq_clr)               uneq_delta <= 1'b0;
      if (eval_q && (plm_nx != plm))   plm_delta <= 1'b1;
      else if (plm_clr)                plm_delta <= 1'b0;
    end
  end

  assign irq      = (uneq_delta && !uneq_mask) || (plm_delta && !plm_mask);
  assign ais_uneq = uneq;

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_valid |=> $stable(acc_label));
  // R2
  acc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_label) |-> acc_label == $past(v5_byte[3:1]));
  // R5
  plm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |=> !plm || ($past(acc_label) != '0 && $past(exp_label) != LBL_NOCHK));
  // R6
  uneq_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(uneq) |-> uneq_delta);
  // R6
  plm_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(plm) |-> plm_delta);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (uneq_delta || plm_delta));
endmodule

// File: tb/vt_label_mon_tb_top.sv
`timescale 1ns/1ps
module vt_label_mon_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sf_valid = 1'b0;
  logic [7:0] v5_byte = '0;
  logic [3:0] persist_n = 4'd1;
  logic [2:0] exp_label = 3'd2;
  logic uneq_mask = 1'b0, plm_mask = 1'b0, uneq_clr = 1'b0, plm_clr = 1'b0;
  logic [2:0] acc_label;
  logic uneq, plm, uneq_delta, plm_delta, irq, ais_uneq;

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_cand = 0, m_acc = 0;
  int m_cnt = 0;
  logic m_uneq = 0, m_plm = 0, m_ud = 0, m_pd = 0;

  always #5 clk = ~clk;

  vt_label_mon dut_i (.*);

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic f_irq();
    return (m_ud && !uneq_mask) || (m_pd && !plm_mask);
  endfunction

  function automatic logic f_plm(logic [2:0] a, logic [2:0] e);
    return (a != 0) && (e != 3'd1) && (a != e);
  endfunction

  task automatic chk_defects(string tag);
    chk({tag, " R4 uneq"}, {7'd0, uneq}, {7'd0, m_uneq});
    chk({tag, " R4 ais_uneq"}, {7'd0, ais_uneq}, {7'd0, m_uneq});
    chk({tag, " R5 plm"}, {7'd0, plm}, {7'd0, m_plm});
    chk({tag, " R6 deltas"}, {6'd0, uneq_delta, plm_delta}, {6'd0, m_ud, m_pd});
    chk({tag, " R7 irq"}, {7'd0, irq}, {7'd0, f_irq()});
  endtask

  task automatic send_sf(logic [7:0] v);
    logic nu, np;
    int thr;
    @(negedge clk);
    sf_valid = 1'b1; v5_byte = v;
    thr = (persist_n == 0) ? 1 : int'(persist_n);
    if (v[3:1] == m_cand) m_cnt = (m_cnt == 15) ? 15 : m_cnt + 1;
    else m_cnt = 1;
    m_cand = v[3:1];
    if (m_cnt >= thr) m_acc = m_cand;
    @(posedge clk); #1;
    sf_valid = 1'b0; v5_byte = 8'($urandom);
    chk("R2 R3 acc_label", {5'd0, acc_label}, {5'd0, m_acc});
    nu = (m_acc == 0);
    np = f_plm(m_acc, exp_label);
    if (nu != m_uneq) m_ud = 1;
    if (np != m_plm) m_pd = 1;
    m_uneq = nu; m_plm = np;
    @(posedge clk); #1;
    chk_defects("sf");
  endtask

  task automatic clr(logic u, logic p);
    @(negedge clk);
    uneq_clr = u; plm_clr = p;
    @(negedge clk);
    uneq_clr = 0; plm_clr = 0;
    if (u) m_ud = 0;
    if (p) m_pd = 0;
    #1 chk_defects("clr R6");
  endtask

  initial begin
    void'($urandom(32'h5EED_0007));
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 acc_label", {5'd0, acc_label}, 8'd0);
    chk("R8 flags", {3'd0, uneq, plm, uneq_delta, plm_delta, irq}, 8'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1: label taken from bits [3:1], other bits ignored
    persist_n = 4'd1;
    send_sf(8'b1111_0101);   // label 010
    send_sf(8'b0000_1011);   // label 101 -> plm vs 010
    chk("R1 label 101", {5'd0, acc_label}, 8'd5);
    clr(1, 1);

    // R1: data while sf_valid low ignored
    repeat (4) begin
      @(negedge clk) v5_byte = 8'hFF;
    end
    @(negedge clk); #1;
    chk("R1 idle ignored", {5'd0, acc_label}, 8'd5);

    // R2: persistence 3, interrupted run restarts
    persist_n = 4'd3;
    send_sf(8'b0000_0110);   // 011 run 1
    send_sf(8'b0000_0110);   // run 2
    send_sf(8'b0000_1000);   // 100 restart
    send_sf(8'b0000_0110);   // 011 run 1
    send_sf(8'b0000_0110);
    chk("R2 not yet", {5'd0, acc_label}, 8'd5);
    send_sf(8'b0000_0110);
    chk("R2 accepted", {5'd0, acc_label}, 8'd3);

    // R2: persist 0 acts as 1
    persist_n = 4'd0;
    send_sf(8'b0000_0000);
    chk("R2 zero thr", {5'd0, acc_label}, 8'd0);
    chk("R4 uneq on 000", {7'd0, uneq}, 8'd1);

    // R5: expected 001 suppresses plm
    persist_n = 4'd1;
    exp_label = 3'd1;
    send_sf(8'b0000_1110);
    chk("R5 suppressed", {7'd0, plm}, 8'd0);

    // R9: new expected label re-evaluated without filter restart
    persist_n = 4'd2;
    exp_label = 3'd6;
    send_sf(8'b0000_1110);   // 111 run continues -> no change to acc
    chk("R9 plm", {7'd0, plm}, 8'd1);

    // R7 masks
    uneq_mask = 1; plm_mask = 1;
    #1 chk("R7 masked", {7'd0, irq}, 8'd0);
    uneq_mask = 0; plm_mask = 0;
    clr(1, 1);

    // R6: set wins over clear in same cycle
    persist_n = 4'd1;
    @(negedge clk);
    sf_valid = 1; v5_byte = 8'b0000_1100;   // 110 -> plm clears
    @(negedge clk);
    sf_valid = 0; plm_clr = 1;              // eval cycle with clear
    m_cand = 3'd6; m_cnt = 1; m_acc = 3'd6; m_plm = 0; m_pd = 1;
    @(negedge clk);
    plm_clr = 0;
    chk("R6 set wins", {7'd0, plm_delta}, 8'd1);
    clr(1, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [2:0] l;
      r = int'($urandom_range(0, 9));
      if (r == 0) persist_n = 4'($urandom_range(0, 5));
      if (r == 1) exp_label = 3'($urandom);
      if (r == 2) begin uneq_mask = 1'($urandom); plm_mask = 1'($urandom); end
      if (r == 3) clr(1'($urandom), 1'($urandom));
      l = ($urandom_range(0, 3) == 0) ? 3'($urandom) : m_cand;
      if ($urandom_range(0, 5) == 0) l = 3'd0;
      send_sf({4'($urandom), l, 1'($urandom)});
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule